// File: doc/BRIEF.md
# PTP Frame Classifier

The classifier watches an Ethernet frame as it goes past, one 32-bit word at a time, and decides whether the frame carries a PTP message. It follows the header chain from the MAC addresses through at most two VLAN tags. It then follows any number of stacked MPLS labels. From there it reaches either PTP carried straight over Ethernet, or PTP inside UDP over IPv4 or IPv6. When it finds a PTP header it reports the message type, the sequence number and a 12-bit checksum-derived value on a single-cycle strobe. When a frame fails any test on the way, it raises the same strobe with the "is PTP" flag low.

Words arrive at most once every four clocks. Each word is split into four bytes and handled one byte per clock, so no stage of the header logic needs more than a byte compare per cycle. A word flagged as start of frame restarts the walk, whatever state the walk is in. That lets the block sit beside a MAC receive path and tag frames for a timestamp unit without any handshake.

Top module: `ptp_frame_classifier`

## Requirements
- R1: Byte order is big-endian within a word: bits 31:24 carry the earliest byte. With EtherType 0x88F7 at frame bytes 12-13, the PTP header starts at byte 14. The strobe then reports is-PTP high, the type as the low nibble of PTP header byte 0, and the sequence number as PTP header bytes 30 (high) and 31 (low). The check value is the sum of PTP header bytes 0 to 33, taken modulo 4096.
- R2: A 4-byte tag introduced by EtherType 0x8100 is skipped, and the EtherType that follows it is decoded. One or two tags are accepted. A third tag gives a not-PTP result.
- R3: EtherType 0x0800 leads to an IPv4 header. The high nibble of its first byte must be 4. The low nibble gives the header length in 4-byte units and must be at least 5, and option bytes are skipped. The protocol in byte 9 must be 17 (UDP). The UDP destination port, in bytes 2-3 of the UDP header, must be 319 or 320. The PTP header follows the 8-byte UDP header.
- R4: EtherType 0x86DD leads to a 40-byte IPv6 header. The high nibble of its first byte must be 6 and the next-header byte 6 must be 17. After that the same UDP rule as R3 applies.
- R5: EtherType 0x8847 starts a stack of 4-byte MPLS labels of any length. Bit 0 of byte 2 of a label marks the bottom of the stack. The payload after it is taken as IPv4 if its first nibble is 4 and as IPv6 if it is 6, and anything else is not PTP.
- R6: A frame that fails a test produces one not-PTP strobe with type, sequence and check value all zero. Its remaining bytes produce nothing, even if they look like valid headers. Unknown EtherTypes fail.
- R7: Every frame produces at most one strobe. A start-of-frame word restarts parsing at once, so a frame cut short before its deciding byte produces no strobe.
- R8: Words may arrive every fourth clock, back to back, across frames. The strobe rises on the fourth clock edge after the edge that accepts the word holding the deciding byte, or earlier. It can share a cycle with the acceptance of the next frame's first word.
- R9: After reset the strobe is low and all result outputs are zero. Words before the first start-of-frame word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Input word valid, at most once every 4 clocks |
| in_sof | input | 1 | Qualifies a valid word as the first word of a frame |
| in_data | input | 32 | Frame word, earliest byte in bits 31:24 |
| ptp_strobe | output | 1 | One-cycle classification result strobe |
| ptp_is_ptp | output | 1 | High when the frame carries PTP |
| ptp_msg_type | output | 4 | PTP message type |
| ptp_seq_id | output | 16 | PTP sequence number |
| ptp_ck_frag | output | 12 | Sum of PTP header bytes modulo 4096 |

## Verification
Two events can share a cycle. One is the result strobe for a frame whose PTP header ends on the last byte of its last word. The other is the acceptance of the first word of the next frame. Plain layer-2 PTP frames are exactly 12 words long, so sending two of them back to back with no idle gap lines these up. The scoreboard must then see both results in order, each with its own sequence number. A second case sends a start-of-frame word into a frame still inside its IP header. Only the newer frame may report.

// File: rtl/ptpc_pkg.sv
// Package ptpc_pkg
// Shared constants and types for the PTP frame classifier.
// Assumes big-endian byte order of header fields on the wire.
package ptpc_pkg;

    localparam logic [15:0] ET_VLAN  = 16'h8100;
    localparam logic [15:0] ET_MPLS  = 16'h8847;
    localparam logic [15:0] ET_IPV4  = 16'h0800;
    localparam logic [15:0] ET_IPV6  = 16'h86DD;
    localparam logic [15:0] ET_PTP   = 16'h88F7;
    localparam logic [7:0]  PROTO_UDP = 8'd17;
    localparam logic [15:0] PORT_EVT = 16'd319;
    localparam logic [15:0] PORT_GEN = 16'd320;

    typedef enum logic [3:0] {
        W_IDLE, W_MAC, W_ETYPE, W_VLAN, W_MPLS, W_IPVER,
        W_IPV4, W_IPV6, W_UDP, W_PTP, W_DONE
    } walk_state_t;

    typedef struct packed {
        logic [3:0]  msg;
        logic [15:0] seq;
        logic [11:0] ck;
    } ptp_fields_t;

endpackage

// File: rtl/ptpc_word_serial.sv
// Module ptpc_word_serial
// Splits each accepted word into bytes, earliest byte first, one byte per clock.
// Assumes a new word arrives no sooner than the cycle in which the last byte
// of the previous word is consumed (one word per NBYTES clocks at most).
module ptpc_word_serial #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic              word_sof,
    input  logic [WORD_W-1:0] word_data,
    output logic              byte_vld,
    output logic              byte_sof,
    output logic [7:0]        byte_data
);
    localparam int NBYTES = WORD_W / 8;
    localparam int CNT_W  = $clog2(NBYTES + 1);

    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  left;
    logic              sof_q;

    // Load a new word or shift out the next byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            left  <= '0;
            sof_q <= 1'b0;
        end else if (word_vld) begin
            shreg <= word_data;
            left  <= CNT_W'(NBYTES);
            sof_q <= word_sof;
        end else if (left != '0) begin
            shreg <= shreg << 8;
            left  <= left - 1'b1;
        end
    end

    assign byte_vld  = (left != '0);
    assign byte_data = shreg[WORD_W-1 -: 8];
    assign byte_sof  = sof_q && (left == CNT_W'(NBYTES));

    AST_WORD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> (left <= CNT_W'(1))); // R8

endmodule

// File: rtl/ptpc_hdr_walk.sv
// Module ptpc_hdr_walk
// Byte-serial header walker: MAC, VLAN tags, MPLS stack, IPv4/IPv6, UDP, PTP.
// Emits one registered result strobe per frame. A start-of-frame byte
// restarts the walk from any state. Assumes the byte stream of ptpc_word_serial.
module ptpc_hdr_walk
    import ptpc_pkg::*;
#(
    parameter int MAX_VLAN  = 2,
    parameter int MAC_BYTES = 12,
    parameter int PTP_BYTES = 34,
    parameter int SEQ_OFS   = 30,
    parameter int IPV6_BYTES = 40,
    parameter int UDP_BYTES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_vld,
    input  logic        byte_sof,
    input  logic [7:0]  byte_data,
    output logic        res_vld,
    output logic        res_ptp,
    output ptp_fields_t res_f
);
    localparam int VL_W = $clog2(MAX_VLAN + 1);
    localparam logic [1:0] VER_ANY = 2'd0;
    localparam logic [1:0] VER_4   = 2'd1;
    localparam logic [1:0] VER_6   = 2'd2;

    walk_state_t state, nxt_state;
    logic [7:0]  bc, nxt_bc;
    logic [7:0]  hold;
    logic [VL_W-1:0] vlan_n;
    logic [1:0]  exp_ver;
    logic [3:0]  ihl_q;
    logic        bos_q;
    logic [3:0]  msg_q;
    logic [15:0] seq_q;
    logic [11:0] acc;
    logic        fail_now, ptp_done;
    logic [15:0] pair;
    logic [7:0]  v4_last;
    logic        step;

    assign step    = byte_vld && !byte_sof;
    assign pair    = {hold, byte_data};
    assign v4_last = {2'b00, ihl_q, 2'b00} - 8'd1;

    // Next state, byte index and verdict for the byte in this cycle.
    always_comb begin
        nxt_state = state;
        nxt_bc    = bc;
        fail_now  = 1'b0;
        ptp_done  = 1'b0;
        if (byte_vld && byte_sof) begin
            nxt_state = W_MAC;
            nxt_bc    = 8'd1;
        end else if (byte_vld) begin
            nxt_bc = bc + 8'd1;
            unique case (state)
                W_MAC: if (bc == 8'(MAC_BYTES - 1)) begin
                    nxt_state = W_ETYPE;
                    nxt_bc    = '0;
                end
                W_ETYPE: if (bc == 8'd1) begin
                    nxt_bc = '0;
                    case (pair)
                        ET_VLAN: if (vlan_n == VL_W'(MAX_VLAN)) fail_now = 1'b1;
                                 else nxt_state = W_VLAN;
                        ET_MPLS: nxt_state = W_MPLS;
                        ET_IPV4, ET_IPV6: nxt_state = W_IPVER;
                        ET_PTP:  nxt_state = W_PTP;
                        default: fail_now = 1'b1;
                    endcase
                end
                W_VLAN: if (bc == 8'd1) begin
                    nxt_state = W_ETYPE;
                    nxt_bc    = '0;
                end
                W_MPLS: if (bc == 8'd3) begin
                    nxt_bc    = '0;
                    nxt_state = bos_q ? W_IPVER : W_MPLS;
                end
                W_IPVER: begin
                    if (byte_data[7:4] == 4'd4 && exp_ver != VER_6 && byte_data[3:0] >= 4'd5)
                        nxt_state = W_IPV4;
                    else if (byte_data[7:4] == 4'd6 && exp_ver != VER_4)
                        nxt_state = W_IPV6;
                    else
                        fail_now = 1'b1;
                end
                W_IPV4: begin
                    if (bc == 8'd9 && byte_data != PROTO_UDP) fail_now = 1'b1;
                    else if (bc == v4_last) begin
                        nxt_state = W_UDP;
                        nxt_bc    = '0;
                    end
                end
                W_IPV6: begin
                    if (bc == 8'd6 && byte_data != PROTO_UDP) fail_now = 1'b1;
                    else if (bc == 8'(IPV6_BYTES - 1)) begin
                        nxt_state = W_UDP;
                        nxt_bc    = '0;
                    end
                end
                W_UDP: begin
                    if (bc == 8'd3 && pair != PORT_EVT && pair != PORT_GEN) fail_now = 1'b1;
                    else if (bc == 8'(UDP_BYTES - 1)) begin
                        nxt_state = W_PTP;
                        nxt_bc    = '0;
                    end
                end
                W_PTP: if (bc == 8'(PTP_BYTES - 1)) begin
                    ptp_done  = 1'b1;
                    nxt_state = W_DONE;
                end
                default: nxt_bc = bc;
            endcase
            if (fail_now) nxt_state = W_DONE;
        end
    end

    // State, byte index and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= W_IDLE;
            bc      <= '0;
            res_vld <= 1'b0;
            res_ptp <= 1'b0;
            res_f   <= '0;
        end else begin
            state   <= nxt_state;
            bc      <= nxt_bc;
            res_vld <= fail_now || ptp_done;
            if (ptp_done) begin
                res_ptp <= 1'b1;
                res_f   <= '{msg: msg_q, seq: seq_q, ck: acc + 12'(byte_data)};
            end else if (fail_now) begin
                res_ptp <= 1'b0;
                res_f   <= '0;
            end
        end
    end

    // Captured header fields used by later bytes of the walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold    <= '0;
            vlan_n  <= '0;
            exp_ver <= VER_ANY;
            ihl_q   <= '0;
            bos_q   <= 1'b0;
            msg_q   <= '0;
            seq_q   <= '0;
            acc     <= '0;
        end else begin
            if (byte_vld) hold <= byte_data;
            if (byte_vld && byte_sof) vlan_n <= '0;
            if (step && state == W_ETYPE && bc == 8'd1) begin
                if (pair == ET_VLAN && vlan_n != VL_W'(MAX_VLAN)) vlan_n <= vlan_n + 1'b1;
                exp_ver <= (pair == ET_IPV4) ? VER_4 : (pair == ET_IPV6) ? VER_6 : VER_ANY;
            end
            if (step && state == W_MPLS && bc == 8'd2) bos_q <= byte_data[0];
            if (step && state == W_IPVER) ihl_q <= byte_data[3:0];
            if (step && state == W_PTP) begin
                if (bc == '0) begin
                    acc   <= 12'(byte_data);
                    msg_q <= byte_data[3:0];
                end else begin
                    acc <= acc + 12'(byte_data);
                end
                if (bc == 8'(SEQ_OFS + 1)) seq_q <= pair;
            end
        end
    end

    // Tracks whether the current frame has already reported.
    logic reported;
    always_ff @(posedge clk) begin
        if (!rst_n)                    reported <= 1'b0;
        else if (byte_vld && byte_sof) reported <= 1'b0;
        else if (res_vld)              reported <= 1'b1;
    end

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> !reported); // R7
    AST_NOT_PTP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !res_ptp) |-> (res_f == '0)); // R6
    AST_STROBE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> $past(byte_vld)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == W_IDLE) |-> !res_vld); // R9

endmodule

// File: rtl/ptp_frame_classifier.sv
// Module ptp_frame_classifier
// Top level: word-to-byte serializer feeding the header walker.
// Assumes in_vld at most once every four clocks and in_sof only with in_vld.
module ptp_frame_classifier
    import ptpc_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int MAX_VLAN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic              in_sof,
    input  logic [WORD_W-1:0] in_data,
    output logic              ptp_strobe,
    output logic              ptp_is_ptp,
    output logic [3:0]        ptp_msg_type,
    output logic [15:0]       ptp_seq_id,
    output logic [11:0]       ptp_ck_frag
);
    logic        b_vld, b_sof;
    logic [7:0]  b_data;
    ptp_fields_t fields;

    ptpc_word_serial #(.WORD_W(WORD_W)) u_ser (
        .clk(clk), .rst_n(rst_n),
        .word_vld(in_vld), .word_sof(in_sof), .word_data(in_data),
        .byte_vld(b_vld), .byte_sof(b_sof), .byte_data(b_data)
    );

    ptpc_hdr_walk #(.MAX_VLAN(MAX_VLAN)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .byte_vld(b_vld), .byte_sof(b_sof), .byte_data(b_data),
        .res_vld(ptp_strobe), .res_ptp(ptp_is_ptp), .res_f(fields)
    );

    assign ptp_msg_type = fields.msg;
    assign ptp_seq_id   = fields.seq;
    assign ptp_ck_frag  = fields.ck;

endmodule

// File: tb/sim_ptp_frame_classifier.sv
module sim_ptp_frame_classifier;
    logic        clk = 1'b0, rst_n = 1'b0, in_vld = 1'b0, in_sof = 1'b0;
    logic [31:0] in_data = '0;
    logic        ptp_strobe, ptp_is_ptp;
    logic [3:0]  ptp_msg_type;
    logic [15:0] ptp_seq_id;
    logic [11:0] ptp_ck_frag;

    ptp_frame_classifier u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sof(in_sof), .in_data(in_data),
        .ptp_strobe(ptp_strobe), .ptp_is_ptp(ptp_is_ptp), .ptp_msg_type(ptp_msg_type),
        .ptp_seq_id(ptp_seq_id), .ptp_ck_frag(ptp_ck_frag)
    );

    always #4 clk = ~clk;   // 125 MHz

    typedef struct {
        logic ptp; logic [3:0] msg; logic [15:0] seq; logic [11:0] ck; string req;
    } exp_t;

    exp_t        sb[$];
    logic [7:0]  fb[$];
    int          n_chk = 0, n_bad = 0, n_strobe = 0, n_exp = 0;
    logic [3:0]  e_msg;
    logic [15:0] e_seq;
    logic [11:0] e_ck;

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Monitor: pops the scoreboard on each strobe and compares.
    always @(negedge clk) begin
        if (rst_n && ptp_strobe) begin
            exp_t e;
            n_strobe++;
            n_chk++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL R7 extra strobe: actual ptp=%0d seq=%h expected none", ptp_is_ptp, ptp_seq_id);
            end else begin
                e = sb.pop_front();
                if (ptp_is_ptp !== e.ptp || ptp_msg_type !== e.msg || ptp_seq_id !== e.seq || ptp_ck_frag !== e.ck) begin
                    n_bad++;
                    $display("FAIL %s: actual ptp=%0d msg=%h seq=%h ck=%h expected ptp=%0d msg=%h seq=%h ck=%h",
                             e.req, ptp_is_ptp, ptp_msg_type, ptp_seq_id, ptp_ck_frag, e.ptp, e.msg, e.seq, e.ck);
                end
            end
        end
    end

    task automatic b8(input logic [7:0] v); fb.push_back(v); endtask
    task automatic b16(input logic [15:0] v); b8(v[15:8]); b8(v[7:0]); endtask
    task automatic eth(); for (int i = 0; i < 12; i++) b8(8'h10 + 8'(i)); endtask
    task automatic vlan(input int n); repeat (n) begin b16(16'h8100); b16(16'h0064); end endtask
    task automatic mpls(input int n);
        for (int i = 0; i < n; i++) begin b8(8'h00); b8(8'h12); b8({7'h18, i == n - 1}); b8(8'h40); end
    endtask
    task automatic ipv4(input int ihl, input logic [7:0] proto);
        b8({4'h4, 4'(ihl)}); b8(8'h00); b16(16'h0050); b16(16'h1234); b16(16'h0000);
        b8(8'h40); b8(proto); b16(16'h0000);
        for (int i = 0; i < 8; i++) b8(8'hC0 + 8'(i));
        for (int i = 0; i < (ihl - 5) * 4; i++) b8(8'h01);
    endtask
    task automatic ipv6(input logic [7:0] nh);
        b8(8'h60); b8(8'h00); b16(16'h0000); b16(16'h0036); b8(nh); b8(8'h40);
        for (int i = 0; i < 32; i++) b8(8'hFE - 8'(i));
    endtask
    task automatic udp(input logic [15:0] dport);
        b16(16'h0400); b16(dport); b16(16'h0036); b16(16'h0000);
    endtask
    task automatic ptp(input logic [3:0] msg, input logic [15:0] seq, input logic [7:0] seed);
        logic [7:0] v;
        e_msg = msg; e_seq = seq; e_ck = '0;
        for (int i = 0; i < 34; i++) begin
            v = (i == 0) ? {4'hA, msg} : (i == 30) ? seq[15:8] : (i == 31) ? seq[7:0] : seed + 8'(i * 7);
            e_ck = e_ck + 12'(v);
            b8(v);
        end
    endtask
    task automatic push_exp(input logic ok, input string req);
        exp_t e;
        e.ptp = ok; e.req = req;
        e.msg = ok ? e_msg : '0; e.seq = ok ? e_seq : '0; e.ck = ok ? e_ck : '0;
        sb.push_back(e);
        n_exp++;
    endtask

    // Driver: one word every fourth clock; gap>0 waits and checks the result arrived (R8).
    task automatic send(input int gap);
        int nw;
        while (fb.size() % 4 != 0) b8(8'h00);
        nw = fb.size() / 4;
        for (int w = 0; w < nw; w++) begin
            @(posedge clk); #1;
            in_vld = 1'b1; in_sof = (w == 0);
            in_data = {fb[4*w], fb[4*w+1], fb[4*w+2], fb[4*w+3]};
            @(posedge clk); #1;
            in_vld = 1'b0; in_sof = 1'b0;
            @(posedge clk);
            @(posedge clk);
        end
        fb.delete();
        if (gap > 0) begin
            repeat (gap) @(posedge clk);
            #1;
            n_chk++;
            if (sb.size() != 0) begin
                n_bad++;
                $display("FAIL R8 result late: actual pending=%0d expected 0", sb.size());
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R7 watchdog: actual hung expected done");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        n_chk++;   // R9 reset state
        if (ptp_strobe !== 1'b0 || ptp_is_ptp !== 1'b0 || ptp_seq_id !== '0 || ptp_ck_frag !== '0 || ptp_msg_type !== '0) begin
            n_bad++;
            $display("FAIL R9 reset: actual strobe=%0d ptp=%0d seq=%h expected all zero", ptp_strobe, ptp_is_ptp, ptp_seq_id);
        end

        // R9: words without a start of frame are ignored.
        for (int w = 0; w < 12; w++) begin
            @(posedge clk); #1; in_vld = 1'b1; in_sof = 1'b0; in_data = 32'h88F7_88F7;
            @(posedge clk); #1; in_vld = 1'b0;
            @(posedge clk); @(posedge clk);
        end
        repeat (6) @(posedge clk);
        n_chk++;
        if (n_strobe != 0) begin
            n_bad++;
            $display("FAIL R9 pre-sof words: actual strobes=%0d expected 0", n_strobe);
        end

        // R1 plain layer-2 PTP.
        eth(); b16(16'h88F7); ptp(4'h0, 16'h1234, 8'h21); push_exp(1, "R1 l2"); send(3);
        eth(); b16(16'h88F7); ptp(4'hB, 16'hFFFE, 8'hE0); push_exp(1, "R1 l2 wrap"); send(3);
        // R2 tags.
        eth(); vlan(1); b16(16'h88F7); ptp(4'h1, 16'h0101, 8'h33); push_exp(1, "R2 one tag"); send(3);
        eth(); vlan(2); b16(16'h0800); ipv4(5, 8'd17); udp(16'd319); ptp(4'h2, 16'h0202, 8'h44);
        push_exp(1, "R2 two tags"); send(3);
        eth(); vlan(3); b16(16'h88F7); ptp(4'h3, 16'h0303, 8'h55); push_exp(0, "R2 three tags"); send(3);
        // R3 IPv4.
        eth(); b16(16'h0800); ipv4(5, 8'd17); udp(16'd319); ptp(4'h8, 16'h4000, 8'h66); push_exp(1, "R3 ihl5 319"); send(3);
        eth(); vlan(1); b16(16'h0800); ipv4(7, 8'd17); udp(16'd320); ptp(4'h9, 16'h4001, 8'h77); push_exp(1, "R3 ihl7 320"); send(3);
        eth(); b16(16'h0800); ipv4(5, 8'd6); udp(16'd319); ptp(4'h0, 16'h4002, 8'h88); push_exp(0, "R3 proto tcp"); send(3);
        eth(); b16(16'h0800); ipv4(5, 8'd17); udp(16'd321); ptp(4'h0, 16'h4003, 8'h99); push_exp(0, "R3 port 321"); send(3);
        eth(); b16(16'h0800); ipv4(4, 8'd17); udp(16'd319); ptp(4'h0, 16'h4004, 8'h99); push_exp(0, "R3 ihl4"); send(3);
        // R4 IPv6.
        eth(); b16(16'h86DD); ipv6(8'd17); udp(16'd319); ptp(4'hC, 16'h6000, 8'hAA); push_exp(1, "R4 v6 319"); send(3);
        eth(); b16(16'h86DD); ipv6(8'd6); udp(16'd319); ptp(4'hC, 16'h6001, 8'hAB); push_exp(0, "R4 v6 nh6"); send(3);
        // R5 MPLS stacks.
        eth(); b16(16'h8847); mpls(1); ipv4(5, 8'd17); udp(16'd320); ptp(4'h1, 16'h7000, 8'hBB); push_exp(1, "R5 one label"); send(3);
        eth(); vlan(1); b16(16'h8847); mpls(3); ipv6(8'd17); udp(16'd319); ptp(4'h8, 16'h7001, 8'hCC);
        push_exp(1, "R5 three labels v6"); send(3);
        eth(); b16(16'h8847); mpls(2); b8(8'h50); b8(8'h00); b16(16'h0000); push_exp(0, "R5 bad payload"); send(3);
        // R6 unknown type, and trailing PTP-like bytes after a failure.
        eth(); b16(16'h0806); b16(16'h88F7); ptp(4'h0, 16'h0BAD, 8'h01); push_exp(0, "R6 unknown type"); send(3);
        eth(); b16(16'h0800); ipv4(5, 8'd1); eth(); b16(16'h88F7); ptp(4'h3, 16'h0BAE, 8'h02);
        push_exp(0, "R6 ignore tail"); send(3);
        // R7 truncated frame restarted by a new start of frame.
        eth(); b16(16'h0800); b8(8'h45); b8(8'h00); send(0);
        eth(); b16(16'h88F7); ptp(4'h4, 16'h5151, 8'h10); push_exp(1, "R7 restart"); send(3);
        // R8 back to back: result of first shares a cycle with the next frame's first word.
        eth(); b16(16'h88F7); ptp(4'h5, 16'hA001, 8'h20); push_exp(1, "R8 b2b first"); send(0);
        eth(); b16(16'h88F7); ptp(4'h6, 16'hA002, 8'h30); push_exp(1, "R8 b2b second"); send(0);
        eth(); b16(16'h88F7); ptp(4'h7, 16'hA003, 8'h40); push_exp(1, "R8 b2b third"); send(3);

        repeat (10) @(posedge clk);
        n_chk++;
        if (sb.size() != 0 || n_strobe != n_exp) begin
            n_bad++;
            $display("FAIL R7 strobe count: actual %0d expected %0d", n_strobe, n_exp);
        end
        report();
    end
endmodule